// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block sits beside the command controller of a serial memory and decides what may be written. It holds the status register fields that govern protection: a hardware-protect enable flag and a block-protect level. It also holds the write-enable latch. From these fields and the level of the external write-protect pin, it derives three permissions. The first says whether the status register may be written. The second says whether the unprotected part of the array may be written. The third says whether the address now presented may be written.

The controller raises the latch with a write-enable command and drops it with a write-disable command or at the end of a write cycle. It offers status register updates as one-cycle requests, and the unit applies them only when the status register is writable. The write-protect pin is asynchronous to the clock, so it passes through a two-flop synchronizer before it affects any permission. The block-protect level selects one protected region at the top of the address space: none, the top quarter, the top half, or the whole array.

Top module: `sr_guard`

## Requirements
- R1: After reset, the write-enable latch, the protect-enable flag and the protect level all read 0, and the status permission and unprotected-array permission are both 0.
- R2: A write-enable pulse sets the latch at the next clock edge and a write-disable pulse clears it; when both are asserted in the same cycle, the latch ends up cleared.
- R3: While the latch is 0, no permission output is 1, and a status write request leaves the protect-enable flag and the protect level unchanged.
- R4: With the protect-enable flag at 0 and the latch at 1, the status register and the unprotected array are writable whatever the pin level.
- R5: With the protect-enable flag at 1, the synchronized pin low and the latch at 1, the unprotected array is writable but the status register is not.
- R6: With the synchronized pin high and the latch at 1, the status register and the unprotected array are writable whatever the protect-enable flag.
- R7: While the protect-enable flag is 1 and the synchronized pin is low, a request to clear the flag or to change the level has no effect.
- R8: The address-protected output follows the 2-bit protect level as follows. Level 0 protects no address. Level 1 protects addresses at or above 3/4 of the address space. Level 2 protects addresses at or above 1/2 of it. Level 3 protects every address.
- R9: The array-write permission for the presented address is 1 only when the latch is 1 and the address is not protected, so protected addresses are never writable.
- R10: A change of the write-protect pin reaches the permissions after exactly two rising clock edges; after one edge, the old level still applies.
- R11: An allowed status write takes effect at the next clock edge, and its new flag and level values appear on the status outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin_i | input | 1 | External write-protect pin, asynchronous, low means protect |
| wel_set_i | input | 1 | Write-enable command pulse |
| wel_clr_i | input | 1 | Write-disable or end-of-write-cycle pulse |
| sr_wr_req_i | input | 1 | Status register write request |
| sr_wr_wpen_i | input | 1 | Requested protect-enable flag value |
| sr_wr_lvl_i | input | LVL_W | Requested protect level |
| addr_i | input | ADDR_W | Array address under consideration |
| wel_o | output | 1 | Write-enable latch state |
| wpen_o | output | 1 | Protect-enable flag |
| lvl_o | output | LVL_W | Protect level |
| sr_wr_ok_o | output | 1 | Status register may be written |
| unprot_wr_ok_o | output | 1 | Unprotected array region may be written |
| addr_prot_o | output | 1 | addr_i lies in the protected region |
| array_wr_ok_o | output | 1 | addr_i may be written |

## Verification
The hardest state to reach is a locked register. In that state, the protect-enable flag is 1, the latch is 1 and the synchronized pin is low, and an attempt to clear the flag must be refused. The stimulus gets there in a fixed order. It first keeps the pin low, raises the latch and writes the flag to 1 while the flag is still 0 and the write is allowed. It then tries to undo that write. Afterwards, it raises the pin and checks the permissions one edge and two edges later, which exposes the synchronizer latency and shows that the lock releases.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  localparam int unsigned LVL_W_DEF  = 2;
  localparam int unsigned ADDR_W_DEF = 17;

  typedef struct packed {
    logic wr_ok_sr;
    logic wr_ok_unprot;
    logic wr_ok_addr;
  } perm_t;
endpackage

// File: rtl/sr_wp_sync.sv
module sr_wp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sr_prot_range.sv
module sr_prot_range #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned LVL_W  = 2
) (
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned NLVL = 1 << LVL_W;
  localparam logic [ADDR_W:0] SPAN = {1'b1, {ADDR_W{1'b0}}};

  logic [NLVL-1:0] lvl_hit;

  assign lvl_hit[0] = 1'b0;

  genvar k;
  generate
    for (k = 1; k < NLVL; k++) begin : g_lvl
      localparam logic [ADDR_W:0] BASE = SPAN - (SPAN >> (NLVL - 1 - k));
      assign lvl_hit[k] = ({1'b0, addr_i} >= BASE);
    end
  endgenerate

  assign hit_o = lvl_hit[lvl_i];
endmodule

// File: rtl/sr_status_regs.sv
module sr_status_regs #(
  parameter int unsigned LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wel_set_i,
  input  logic             wel_clr_i,
  input  logic             wr_en_i,
  input  logic             wr_wpen_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  input  logic             wp_s_i,
  output logic             wel_o,
  output logic             wpen_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic             wel_q,  wel_d;
  logic             wpen_q, wpen_d;
  logic [LVL_W-1:0] lvl_q,  lvl_d;

  always_comb begin
    wel_d  = wel_q;
    wpen_d = wpen_q;
    lvl_d  = lvl_q;
    if (wel_clr_i)      wel_d = 1'b0;
    else if (wel_set_i) wel_d = 1'b1;
    if (wr_en_i) begin
      wpen_d = wr_wpen_i;
      lvl_d  = wr_lvl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      wpen_q <= 1'b0;
      lvl_q  <= '0;
    end else begin
      wel_q  <= wel_d;
      wpen_q <= wpen_d;
      lvl_q  <= lvl_d;
    end
  end

  assign wel_o  = wel_q;
  assign wpen_o = wpen_q;
  assign lvl_o  = lvl_q;

  assert_clr_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_i |=> !wel_q);
  assert_no_wel_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_q |=> ($stable(wpen_q) && $stable(lvl_q)));
  assert_wpen_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen_q && !wp_s_i) |=> (wpen_q && $stable(lvl_q)));
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned LVL_W  = LVL_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin_i,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              sr_wr_req_i,
  input  logic              sr_wr_wpen_i,
  input  logic [LVL_W-1:0]  sr_wr_lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wel_o,
  output logic              wpen_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              sr_wr_ok_o,
  output logic              unprot_wr_ok_o,
  output logic              addr_prot_o,
  output logic              array_wr_ok_o
);
  logic             wp_s;
  logic             wel;
  logic             wpen;
  logic [LVL_W-1:0] lvl;
  logic             addr_hit;
  perm_t            perm;

  sr_wp_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (wp_pin_i),
    .sync_o  (wp_s)
  );

  sr_status_regs #(.LVL_W(LVL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wel_set_i (wel_set_i),
    .wel_clr_i (wel_clr_i),
    .wr_en_i   (sr_wr_req_i && perm.wr_ok_sr),
    .wr_wpen_i (sr_wr_wpen_i),
    .wr_lvl_i  (sr_wr_lvl_i),
    .wp_s_i    (wp_s),
    .wel_o     (wel),
    .wpen_o    (wpen),
    .lvl_o     (lvl)
  );

  sr_prot_range #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_range (
    .lvl_i  (lvl),
    .addr_i (addr_i),
    .hit_o  (addr_hit)
  );

  always_comb begin
    perm.wr_ok_unprot = wel;
    perm.wr_ok_sr     = wel && (!wpen || wp_s);
    perm.wr_ok_addr   = wel && !addr_hit;
  end

  assign wel_o          = wel;
  assign wpen_o         = wpen;
  assign lvl_o          = lvl;
  assign sr_wr_ok_o     = perm.wr_ok_sr;
  assign unprot_wr_ok_o = perm.wr_ok_unprot;
  assign addr_prot_o    = addr_hit;
  assign array_wr_ok_o  = perm.wr_ok_addr;

  assert_prot_never_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> !array_wr_ok_o);
  assert_lvl0_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |-> !addr_hit);
  assert_locked_sr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_s) |-> !sr_wr_ok_o);
  assert_no_wel_perm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |-> !(sr_wr_ok_o || unprot_wr_ok_o || array_wr_ok_o));
endmodule

// File: tb/sr_guard_test.sv
module sr_guard_test;
  localparam int ADDR_W = 17;
  localparam int LVL_W  = 2;
  localparam int SPAN   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wp_pin;
  logic              wel_set, wel_clr, sr_req, sr_wpen;
  logic [LVL_W-1:0]  sr_lvl;
  logic [ADDR_W-1:0] addr;
  logic              wel, wpen, sr_ok, unprot_ok, addr_prot, arr_ok;
  logic [LVL_W-1:0]  lvl;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sr_guard #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) uut (
    .clk(clk), .rst_n(rst_n), .wp_pin_i(wp_pin),
    .wel_set_i(wel_set), .wel_clr_i(wel_clr),
    .sr_wr_req_i(sr_req), .sr_wr_wpen_i(sr_wpen), .sr_wr_lvl_i(sr_lvl),
    .addr_i(addr), .wel_o(wel), .wpen_o(wpen), .lvl_o(lvl),
    .sr_wr_ok_o(sr_ok), .unprot_wr_ok_o(unprot_ok),
    .addr_prot_o(addr_prot), .array_wr_ok_o(arr_ok)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wren();
    wel_set = 1'b1; tick(); wel_set = 1'b0;
  endtask

  task automatic sr_write(logic f, logic [LVL_W-1:0] l);
    sr_req = 1'b1; sr_wpen = f; sr_lvl = l; tick(); sr_req = 1'b0;
  endtask

  task automatic set_pin(logic v);
    wp_pin = v; tick(); tick();
  endtask

  task automatic t_reset();
    chk("R1 wel", wel, 0);
    chk("R1 wpen", wpen, 0);
    chk("R1 lvl", lvl, 0);
    chk("R1 sr_ok", sr_ok, 0);
    chk("R1 unprot_ok", unprot_ok, 0);
  endtask

  task automatic t_latch();
    sr_write(1'b1, 2'd3);
    chk("R3 wpen unchanged", wpen, 0);
    chk("R3 lvl unchanged", lvl, 0);
    addr = '0;
    #1 chk("R3 arr_ok", arr_ok, 0);
    chk("R3 sr_ok", sr_ok, 0);
    wren();
    chk("R2 set", wel, 1);
    wel_set = 1'b1; wel_clr = 1'b1; tick(); wel_set = 1'b0; wel_clr = 1'b0;
    chk("R2 clear wins", wel, 0);
    wren();
    wel_clr = 1'b1; tick(); wel_clr = 1'b0;
    chk("R2 clear", wel, 0);
  endtask

  task automatic t_open();
    wren();
    chk("R4 sr_ok pin low", sr_ok, 1);
    chk("R4 unprot pin low", unprot_ok, 1);
    set_pin(1'b1);
    chk("R4 sr_ok pin high", sr_ok, 1);
    set_pin(1'b0);
    sr_write(1'b0, 2'd2);
    chk("R11 lvl", lvl, 2);
    chk("R11 wpen", wpen, 0);
  endtask

  task automatic t_ranges();
    sr_write(1'b0, 2'd0);
    addr = ADDR_W'(SPAN - 1); #1 chk("R8 lvl0 top", addr_prot, 0);
    chk("R9 lvl0 ok", arr_ok, 1);
    tick(); sr_write(1'b0, 2'd1);
    addr = ADDR_W'(SPAN / 4 * 3 - 1); #1 chk("R8 lvl1 below", addr_prot, 0);
    addr = ADDR_W'(SPAN / 4 * 3);     #1 chk("R8 lvl1 at", addr_prot, 1);
    chk("R9 lvl1 blocked", arr_ok, 0);
    tick(); sr_write(1'b0, 2'd2);
    addr = ADDR_W'(SPAN / 2 - 1); #1 chk("R8 lvl2 below", addr_prot, 0);
    addr = ADDR_W'(SPAN / 2);     #1 chk("R8 lvl2 at", addr_prot, 1);
    tick(); sr_write(1'b0, 2'd3);
    addr = '0; #1 chk("R8 lvl3 zero", addr_prot, 1);
    chk("R9 lvl3 blocked", arr_ok, 0);
    chk("R9 unprot still ok", unprot_ok, 1);
    tick(); sr_write(1'b0, 2'd0);
  endtask

  task automatic t_lock();
    sr_write(1'b1, 2'd1);
    chk("R11 wpen set", wpen, 1);
    chk("R5 sr blocked", sr_ok, 0);
    chk("R5 unprot ok", unprot_ok, 1);
    sr_write(1'b0, 2'd0);
    chk("R7 wpen held", wpen, 1);
    chk("R7 lvl held", lvl, 1);
    wp_pin = 1'b1; tick();
    chk("R10 one edge", sr_ok, 0);
    tick();
    chk("R10 two edges", sr_ok, 1);
    chk("R6 unprot", unprot_ok, 1);
    sr_write(1'b0, 2'd2);
    chk("R6 wpen cleared", wpen, 0);
    chk("R6 lvl", lvl, 2);
  endtask

  initial begin
    rst_n = 1'b0; wp_pin = 1'b0; wel_set = 1'b0; wel_clr = 1'b0;
    sr_req = 1'b0; sr_wpen = 1'b0; sr_lvl = '0; addr = '0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_latch();
    t_open();
    t_ranges();
    t_lock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule